// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

The block runs once per `start` pulse. It reads a three-wire serial EEPROM that holds 64 words of 16 bits (128 bytes) and turns the contents into the configuration that a hub's descriptor logic uses. It first reads the four header words (bytes 00h to 07h) and checks an additive checksum over the vendor and product ID bytes. When the checksum matches, the IDs, the downstream port count, the non-removable port map and the power budget are taken from the image. Fields that lie outside their legal range fall back to the built-in default one field at a time. When the EEPROM does not answer, or the checksum fails, every field keeps its default value.

After an accepted header, the loader reads words 8 to 63 and sends the characters of the three text regions (vendor, product, serial number) out on a valid/ready byte stream. Each byte is tagged with its region and its character index. The length byte at the head of each region sets how many characters are sent. A consumer may hold `str_ready` low for any number of cycles. The loader keeps the presented byte unchanged during that time, and it starts no new EEPROM word while the previous word's bytes are still waiting. `ee_present` reports that an EEPROM answered, so that the amber LED drivers sharing its wires can be held off.

Top module: `ee_cfg_loader`

## Requirements
- R1: Each word read raises `ee_cs`, then sends on `ee_di` a start bit of 1, the opcode bits 1,0 and a 6-bit word address, MSB first. Each bit is valid at a rising `ee_sk`. The EEPROM then returns a 0 dummy bit and 16 data bits, MSB first, and each of these is sampled as `ee_sk` rises. Word n carries byte 2n in bits 7:0 and byte 2n+1 in bits 15:8. Header words are read in the order 0, 1, 2, 3. Text words are read in the order 8 to 63.
- R2: `ee_sk` stays high and stays low for `clk_div`+1 clock cycles each. `ee_sk` is high only while `ee_cs` is high. Between two words, `ee_cs` stays low for at least `clk_div`+1 cycles.
- R3: If the dummy bit of word 0 reads 1, the EEPROM is absent. No further word is read, every configuration output holds its default, and `done` rises.
- R4: The image is accepted only when byte 04h equals (byte 00h + 01h + 02h + 03h + 1) mod 256. On a mismatch, only words 0 to 3 are read, all outputs keep their defaults, and no text byte is sent.
- R5: On acceptance, `cfg_vid` = {byte 01h, byte 00h}, `cfg_pid` = {byte 03h, byte 02h` }`, and `cfg_removable` = byte 06h bits 3:0. Bit 0 is port 1, and a 1 marks the port non-removable.
- R6: Byte 05h sets `cfg_ports` only when its value is 1 to 4. Any other value leaves the default.
- R7: Byte 07h sets `cfg_maxpwr` (units of 2 mA) only when its value is at most FAh. A larger value leaves the default.
- R8: `ee_present` is 0 after reset, is cleared by `start`, and rises once the dummy bit of word 0 reads 0. It stays high even when the checksum fails.
- R9: Text regions start at byte 10h (vendor, region code 0), 40h (product, code 1) and 70h (serial, code 2). Each region ends where the next begins, and the serial region ends at 7Fh. The first byte of a region is its length L and is never sent. The bytes that follow are sent in ascending address order with indices 0, 1, 2 and so on. Only indices below L are sent, so a region sends at most 47, 47 or 15 bytes respectively.
- R10: While `str_valid` is high and `str_ready` is low, `str_valid`, `str_region`, `str_index` and `str_data` hold their values. Every byte is delivered exactly once.
- R11: `done` falls on `start` and rises only after the last text byte has been accepted. From `start` until `done`, the configuration outputs show the defaults. Once `done` is high they hold their values until the next `start`.
- R12: After reset, `done`, `ee_cs`, `ee_sk`, `ee_di`, `ee_present` and `str_valid` are 0, and the configuration outputs hold the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Serial clock half period minus one, in system clocks |
| start | input | 1 | Pulse to begin a load |
| done | output | 1 | Load finished, outputs valid |
| ee_present | output | 1 | EEPROM answered; amber LEDs must stay off |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| cfg_vid | output | 16 | Vendor ID |
| cfg_pid | output | 16 | Product ID |
| cfg_ports | output | 3 | Downstream port count |
| cfg_removable | output | 4 | Non-removable map, bit 0 = port 1 |
| cfg_maxpwr | output | 8 | Power budget in 2 mA units |
| str_valid | output | 1 | Text byte available |
| str_ready | input | 1 | Consumer takes the byte |
| str_region | output | 2 | 0 vendor, 1 product, 2 serial |
| str_index | output | 6 | Character index inside the region |
| str_data | output | 8 | Character byte |

## Verification
The bench runs a checksum whose sum wraps past FFh. A loader that did not compare modulo 256 would reject that valid image and report defaults. It also sets port counts of 0 and 5 and power values of FAh and FBh, where a wrong bound lets an illegal count or budget through or throws away a legal one. Text lengths of 0 and a serial length larger than its region check that length bytes are never sent and that output stops at the region end. Runs with a random `str_ready` pattern check that bytes are not dropped or repeated under back-pressure. A slow divider setting checks that the serial clock timing follows `clk_div`. An EEPROM model checks each command and the address order.

// File: rtl/eecl_pkg.sv
package eecl_pkg;
  // 16-bit words in the EEPROM image
  localparam int EE_AW = 6;
  localparam int EE_DW = 16;

  // start bit followed by the read opcode
  localparam logic [2:0] READ_CMD = 3'b110;

  // byte addresses where the text regions begin
  localparam logic [6:0] VEND_BASE = 7'h10;
  localparam logic [6:0] PROD_BASE = 7'h40;
  localparam logic [6:0] SER_BASE  = 7'h70;

  localparam logic [7:0] MAXPWR_LIMIT = 8'hFA;

  typedef enum logic [1:0] {
    RGN_VENDOR  = 2'd0,
    RGN_PRODUCT = 2'd1,
    RGN_SERIAL  = 2'd2,
    RGN_NONE    = 2'd3
  } str_region_e;

  typedef enum logic [2:0] {
    T_IDLE, T_READ, T_EVAL, T_HAND, T_DRAIN
  } ldr_state_e;
endpackage

// File: rtl/eecl_mw_reader.sv
module eecl_mw_reader
  import eecl_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int AW    = EE_AW,
  parameter int DW    = EE_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic          go,
  input  logic [AW-1:0] addr,
  output logic          cs,
  output logic          sk,
  output logic          di,
  input  logic          so,
  output logic          rdy,
  output logic          dummy_ok,
  output logic [DW-1:0] word
);
  localparam int CMD_BITS   = 3 + AW;
  localparam int FRAME_BITS = CMD_BITS + 1 + DW;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] DUMMY_AT = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] LAST_AT  = CNT_W'(FRAME_BITS - 1);

  typedef enum logic [1:0] {P_IDLE, P_LO, P_HI, P_GAP} ph_e;

  ph_e                 st;
  logic [DIV_W-1:0]    cnt;
  logic [CNT_W-1:0]    bitn;
  logic [CMD_BITS-1:0] cmd_sh;
  logic                tick;

  assign tick = (cnt == div);
  assign di   = cs & cmd_sh[CMD_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= P_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      cmd_sh   <= '0;
      cs       <= 1'b0;
      sk       <= 1'b0;
      rdy      <= 1'b0;
      dummy_ok <= 1'b0;
      word     <= '0;
    end else begin
      rdy <= 1'b0;
      case (st)
        P_IDLE: begin
          if (go) begin
            cmd_sh <= {READ_CMD, addr};
            cs     <= 1'b1;
            sk     <= 1'b0;
            bitn   <= '0;
            cnt    <= '0;
            st     <= P_LO;
          end
        end
        P_LO: begin
          if (tick) begin
            cnt <= '0;
            sk  <= 1'b1;
            st  <= P_HI;
            if (bitn == DUMMY_AT) dummy_ok <= ~so;
            else if (bitn > DUMMY_AT) word <= {word[DW-2:0], so};
          end else begin
            cnt <= cnt + DIV_W'(1);
          end
        end
        P_HI: begin
          if (tick) begin
            cnt    <= '0;
            sk     <= 1'b0;
            cmd_sh <= {cmd_sh[CMD_BITS-2:0], 1'b0};
            if (bitn == LAST_AT) begin
              cs <= 1'b0;
              st <= P_GAP;
            end else begin
              bitn <= bitn + CNT_W'(1);
              st   <= P_LO;
            end
          end else begin
            cnt <= cnt + DIV_W'(1);
          end
        end
        default: begin
          if (tick) begin
            cnt <= '0;
            rdy <= 1'b1;
            st  <= P_IDLE;
          end else begin
            cnt <= cnt + DIV_W'(1);
          end
        end
      endcase
    end
  end

  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sk |-> cs); // R2
  AST_CS_BEFORE_SK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sk) |-> $past(cs)); // R2
  AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs) |=> !cs); // R2
endmodule

// File: rtl/eecl_hdr_check.sv
module eecl_hdr_check
  import eecl_pkg::*;
#(
  parameter logic [15:0] DEF_VID    = 16'hC0DE,
  parameter logic [15:0] DEF_PID    = 16'h0A17,
  parameter logic [2:0]  DEF_PORTS  = 3'd4,
  parameter logic [3:0]  DEF_REMOV  = 4'h0,
  parameter logic [7:0]  DEF_MAXPWR = 8'h32
) (
  input  logic [63:0] hdr,
  output logic        img_ok,
  output logic [15:0] vid,
  output logic [15:0] pid,
  output logic [2:0]  ports,
  output logic [3:0]  remov,
  output logic [7:0]  maxpwr
);
  logic [7:0] b [8];
  logic [7:0] sum;

  for (genvar i = 0; i < 8; i++) begin : g_bytes
    assign b[i] = hdr[8*i +: 8];
  end

  assign sum    = b[0] + b[1] + b[2] + b[3] + 8'd1;
  assign img_ok = (b[4] == sum);

  always_comb begin
    if (img_ok) begin
      vid    = {b[1], b[0]};
      pid    = {b[3], b[2]};
      remov  = b[6][3:0];
      ports  = (b[5] >= 8'd1 && b[5] <= 8'd4) ? b[5][2:0] : DEF_PORTS;
      maxpwr = (b[7] <= MAXPWR_LIMIT) ? b[7] : DEF_MAXPWR;
    end else begin
      vid    = DEF_VID;
      pid    = DEF_PID;
      remov  = DEF_REMOV;
      ports  = DEF_PORTS;
      maxpwr = DEF_MAXPWR;
    end
  end
endmodule

// File: rtl/eecl_str_emit.sv
module eecl_str_emit
  import eecl_pkg::*;
#(
  parameter int AW = EE_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  output logic          idle,
  output logic          valid,
  input  logic          ready,
  output logic [1:0]    region,
  output logic [5:0]    index,
  output logic [7:0]    data
);
  logic [1:0]    pend;
  logic [15:0]   w_q;
  logic [AW-1:0] a_q;
  logic [7:0]    len_v, len_p, len_s;

  logic          sel;
  logic [AW:0]   baddr;
  logic [6:0]    off;
  logic [7:0]    rlen;
  str_region_e   rgn;
  logic          is_len;

  always_comb begin
    sel   = ~pend[0];
    baddr = {a_q, sel};
    data  = sel ? w_q[15:8] : w_q[7:0];
    if (baddr >= SER_BASE) begin
      rgn = RGN_SERIAL;  off = baddr - SER_BASE;  rlen = len_s;
    end else if (baddr >= PROD_BASE) begin
      rgn = RGN_PRODUCT; off = baddr - PROD_BASE; rlen = len_p;
    end else if (baddr >= VEND_BASE) begin
      rgn = RGN_VENDOR;  off = baddr - VEND_BASE; rlen = len_v;
    end else begin
      rgn = RGN_NONE;    off = '0;                rlen = '0;
    end
  end

  assign is_len = (off == 7'd0);
  assign valid  = (pend != 2'b00) && (rgn != RGN_NONE) && !is_len &&
                  ({1'b0, off} <= rlen);
  assign idle   = (pend == 2'b00);
  assign region = rgn;
  assign index  = 6'(off - 7'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      w_q   <= '0;
      a_q   <= '0;
      len_v <= '0;
      len_p <= '0;
      len_s <= '0;
    end else if (clear) begin
      pend  <= '0;
      len_v <= '0;
      len_p <= '0;
      len_s <= '0;
    end else if (load) begin
      w_q  <= wdata;
      a_q  <= waddr;
      pend <= 2'b11;
    end else if (pend != 2'b00) begin
      if (rgn != RGN_NONE && is_len) begin
        case (rgn)
          RGN_VENDOR:  len_v <= data;
          RGN_PRODUCT: len_p <= data;
          default:     len_s <= data;
        endcase
        pend[sel] <= 1'b0;
      end else if (valid) begin
        if (ready) pend[sel] <= 1'b0;
      end else begin
        pend[sel] <= 1'b0;
      end
    end
  end

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(data) && $stable(index) && $stable(region)); // R10
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> idle); // R10
  AST_REGION_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> region != RGN_NONE); // R9
endmodule

// File: rtl/ee_cfg_loader.sv
module ee_cfg_loader
  import eecl_pkg::*;
#(
  parameter int          DIV_W      = 8,
  parameter logic [15:0] DEF_VID    = 16'hC0DE,
  parameter logic [15:0] DEF_PID    = 16'h0A17,
  parameter logic [2:0]  DEF_PORTS  = 3'd4,
  parameter logic [3:0]  DEF_REMOV  = 4'h0,
  parameter logic [7:0]  DEF_MAXPWR = 8'h32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             start,
  output logic             done,
  output logic             ee_present,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di,
  input  logic             ee_do,
  output logic [15:0]      cfg_vid,
  output logic [15:0]      cfg_pid,
  output logic [2:0]       cfg_ports,
  output logic [3:0]       cfg_removable,
  output logic [7:0]       cfg_maxpwr,
  output logic             str_valid,
  input  logic             str_ready,
  output logic [1:0]       str_region,
  output logic [5:0]       str_index,
  output logic [7:0]       str_data
);
  localparam logic [EE_AW-1:0] HDR_WORDS  = EE_AW'(4);
  localparam logic [EE_AW-1:0] HDR_LAST   = EE_AW'(3);
  localparam logic [EE_AW-1:0] FIRST_TEXT = EE_AW'(VEND_BASE >> 1);
  localparam logic [EE_AW-1:0] LAST_WORD  = '1;

  ldr_state_e       st;
  logic [EE_AW-1:0] waddr;
  logic             go;
  logic [63:0]      hdr_q;

  logic             ph_rdy, ph_dummy_ok;
  logic [EE_DW-1:0] ph_word;
  logic             em_idle, em_load, em_clear;

  logic             chk_ok;
  logic [15:0]      chk_vid, chk_pid;
  logic [2:0]       chk_ports;
  logic [3:0]       chk_remov;
  logic [7:0]       chk_pwr;

  eecl_mw_reader #(.DIV_W(DIV_W), .AW(EE_AW), .DW(EE_DW)) u_reader (
    .clk(clk), .rst_n(rst_n), .div(clk_div), .go(go), .addr(waddr),
    .cs(ee_cs), .sk(ee_sk), .di(ee_di), .so(ee_do),
    .rdy(ph_rdy), .dummy_ok(ph_dummy_ok), .word(ph_word)
  );

  eecl_hdr_check #(
    .DEF_VID(DEF_VID), .DEF_PID(DEF_PID), .DEF_PORTS(DEF_PORTS),
    .DEF_REMOV(DEF_REMOV), .DEF_MAXPWR(DEF_MAXPWR)
  ) u_check (
    .hdr(hdr_q), .img_ok(chk_ok), .vid(chk_vid), .pid(chk_pid),
    .ports(chk_ports), .remov(chk_remov), .maxpwr(chk_pwr)
  );

  assign em_clear = (st == T_IDLE) && start;
  assign em_load  = (st == T_HAND) && em_idle;

  eecl_str_emit #(.AW(EE_AW)) u_emit (
    .clk(clk), .rst_n(rst_n), .clear(em_clear), .load(em_load),
    .waddr(waddr), .wdata(ph_word), .idle(em_idle),
    .valid(str_valid), .ready(str_ready), .region(str_region),
    .index(str_index), .data(str_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= T_IDLE;
      waddr         <= '0;
      go            <= 1'b0;
      hdr_q         <= '0;
      done          <= 1'b0;
      ee_present    <= 1'b0;
      cfg_vid       <= DEF_VID;
      cfg_pid       <= DEF_PID;
      cfg_ports     <= DEF_PORTS;
      cfg_removable <= DEF_REMOV;
      cfg_maxpwr    <= DEF_MAXPWR;
    end else begin
      go <= 1'b0;
      case (st)
        T_IDLE: begin
          if (start) begin
            done          <= 1'b0;
            ee_present    <= 1'b0;
            cfg_vid       <= DEF_VID;
            cfg_pid       <= DEF_PID;
            cfg_ports     <= DEF_PORTS;
            cfg_removable <= DEF_REMOV;
            cfg_maxpwr    <= DEF_MAXPWR;
            waddr         <= '0;
            go            <= 1'b1;
            st            <= T_READ;
          end
        end
        T_READ: begin
          if (ph_rdy) begin
            if (waddr == '0 && !ph_dummy_ok) begin
              done <= 1'b1;
              st   <= T_IDLE;
            end else if (waddr < HDR_WORDS) begin
              hdr_q[{waddr[1:0], 4'b0000} +: 16] <= ph_word;
              if (waddr == HDR_LAST) begin
                st <= T_EVAL;
              end else begin
                waddr <= waddr + EE_AW'(1);
                go    <= 1'b1;
              end
            end else begin
              st <= T_HAND;
            end
          end
        end
        T_EVAL: begin
          ee_present <= 1'b1;
          if (chk_ok) begin
            waddr <= FIRST_TEXT;
            go    <= 1'b1;
            st    <= T_READ;
          end else begin
            done <= 1'b1;
            st   <= T_IDLE;
          end
        end
        T_HAND: begin
          if (em_idle) begin
            if (waddr == LAST_WORD) begin
              st <= T_DRAIN;
            end else begin
              waddr <= waddr + EE_AW'(1);
              go    <= 1'b1;
              st    <= T_READ;
            end
          end
        end
        default: begin
          if (em_idle) begin
            cfg_vid       <= chk_vid;
            cfg_pid       <= chk_pid;
            cfg_ports     <= chk_ports;
            cfg_removable <= chk_remov;
            cfg_maxpwr    <= chk_pwr;
            done          <= 1'b1;
            st            <= T_IDLE;
          end
        end
      endcase
    end
  end

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ee_cs); // R11
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable({cfg_vid, cfg_pid, cfg_ports, cfg_removable, cfg_maxpwr})); // R11
  AST_PORTS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cfg_ports >= 3'd1 && cfg_ports <= 3'd4)); // R6
  AST_PWR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cfg_maxpwr <= MAXPWR_LIMIT); // R7
  AST_STREAM_NEEDS_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
    str_valid |-> ee_present); // R8
endmodule

// File: tb/ee_cfg_loader_bench.sv
module ee_cfg_loader_bench;
  localparam logic [15:0] D_VID = 16'hC0DE;
  localparam logic [15:0] D_PID = 16'h0A17;
  localparam logic [2:0]  D_PORTS = 3'd4;
  localparam logic [3:0]  D_REM = 4'h0;
  localparam logic [7:0]  D_PWR = 8'h32;

  logic clk = 0, rst_n = 0, start = 0, str_ready = 1;
  logic [7:0] clk_div = 8'd1;
  logic done, ee_present, ee_cs, ee_sk, ee_di, ee_do, str_valid;
  logic [15:0] cfg_vid, cfg_pid;
  logic [2:0] cfg_ports;
  logic [3:0] cfg_removable;
  logic [7:0] cfg_maxpwr, str_data;
  logic [1:0] str_region;
  logic [5:0] str_index;

  always #10 clk = ~clk;

  ee_cfg_loader #(.DIV_W(8), .DEF_VID(D_VID), .DEF_PID(D_PID), .DEF_PORTS(D_PORTS),
                  .DEF_REMOV(D_REM), .DEF_MAXPWR(D_PWR)) u_ee_cfg_loader (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .start(start), .done(done),
    .ee_present(ee_present), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
    .cfg_vid(cfg_vid), .cfg_pid(cfg_pid), .cfg_ports(cfg_ports),
    .cfg_removable(cfg_removable), .cfg_maxpwr(cfg_maxpwr),
    .str_valid(str_valid), .str_ready(str_ready), .str_region(str_region),
    .str_index(str_index), .str_data(str_data));

  int n_checks = 0, n_err = 0;
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- EEPROM model ----------------
  logic [7:0] img [128];
  bit   absent = 0;
  logic do_m = 1'b1;
  logic [8:0] cmd_sh;
  int kbit = 0, cur_addr = 0, exp_addr = 0, words_read = 0, proto_err = 0;
  assign ee_do = do_m;

  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) kbit = 0;
    else begin
      if (kbit < 9) cmd_sh = {cmd_sh[7:0], ee_di};
      if (kbit == 8) begin
        words_read++;
        if (cmd_sh[8:6] != 3'b110 || int'(cmd_sh[5:0]) != exp_addr) proto_err++;
        cur_addr = int'(cmd_sh[5:0]);
        exp_addr = (exp_addr == 3) ? 8 : exp_addr + 1;
      end
      if (!absent) begin
        if (kbit == 8) do_m = 1'b0;
        else if (kbit >= 9 && kbit <= 24) begin
          automatic logic [15:0] w = {img[2*cur_addr+1], img[2*cur_addr]};
          do_m = w[15-(kbit-9)];
        end
      end
      kbit++;
    end
  end

  // timing monitors
  int cyc = 0, t_rise = 0, t_csf = 0, hi_min = 0, hi_max = 0, gap_min = 0;
  always @(posedge clk) cyc++;
  always @(posedge ee_sk) t_rise = cyc;
  always @(negedge ee_sk) if (rst_n) begin
    if (cyc - t_rise < hi_min) hi_min = cyc - t_rise;
    if (cyc - t_rise > hi_max) hi_max = cyc - t_rise;
  end
  always @(negedge ee_cs) t_csf = cyc;
  always @(posedge ee_cs) if (rst_n && cyc - t_csf < gap_min) gap_min = cyc - t_csf;

  // ---------------- stream sink ----------------
  bit bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] got [3][48];
  int cnt_rx [3];
  int seq_err = 0, last_r = 0;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    str_ready = bp_mode ? lfsr[0] : 1'b1;
    if (rst_n && str_valid && str_ready) begin
      automatic int r = int'(str_region);
      if (r > 2 || r < last_r) seq_err++;
      else begin
        if (int'(str_index) != cnt_rx[r] || cnt_rx[r] >= 48) seq_err++;
        else got[r][cnt_rx[r]] = str_data;
        cnt_rx[r]++;
        last_r = r;
      end
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [7:0] ch(int r, int i);
    return (r == 0) ? 8'(8'h41 + i) : (r == 1) ? 8'(8'h61 + i) : 8'(8'h30 + i);
  endfunction

  task automatic make_img(input logic [15:0] vid, input logic [15:0] pid,
                          input logic [7:0] ports, input logic [7:0] rem,
                          input logic [7:0] pwr, input bit good_sum,
                          input int vl, input int pl, input int sl);
    for (int i = 0; i < 128; i++) img[i] = 8'hEE;
    img[0] = vid[7:0]; img[1] = vid[15:8]; img[2] = pid[7:0]; img[3] = pid[15:8];
    img[4] = 8'(img[0] + img[1] + img[2] + img[3] + 8'd1) ^ (good_sum ? 8'h00 : 8'h01);
    img[5] = ports; img[6] = rem; img[7] = pwr;
    img[8'h10] = 8'(vl); img[8'h40] = 8'(pl); img[8'h70] = 8'(sl);
    for (int i = 0; i < 47; i++) img[8'h11 + i] = ch(0, i);
    for (int i = 0; i < 47; i++) img[8'h41 + i] = ch(1, i);
    for (int i = 0; i < 15; i++) img[8'h71 + i] = ch(2, i);
  endtask

  task automatic run_load(input string req);
    words_read = 0; exp_addr = 0; proto_err = 0; seq_err = 0; last_r = 0;
    for (int r = 0; r < 3; r++) cnt_rx[r] = 0;
    hi_min = 1000; hi_max = 0; gap_min = 1000;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (3) @(negedge clk);
    check({req, " done low and defaults during load"}, {done, cfg_vid}, {1'b0, D_VID});
    for (int i = 0; i < 40000 && !done; i++) @(negedge clk);
    check({req, " watchdog: done reached"}, done, 1'b1);
  endtask

  task automatic check_text(input string req, input int vl, input int pl, input int sl);
    automatic int lim [3] = '{47, 47, 15};
    automatic int len [3] = '{vl, pl, sl};
    automatic int bad = 0;
    for (int r = 0; r < 3; r++) begin
      automatic int e = (len[r] < lim[r]) ? len[r] : lim[r];
      check({req, " R9 byte count"}, cnt_rx[r], e);
      for (int i = 0; i < e && i < 48; i++) if (got[r][i] !== ch(r, i)) bad++;
    end
    check({req, " R9 text content"}, bad, 0);
    check({req, " R10 order/index"}, seq_err, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R12 reset outputs", {done, ee_present, ee_cs, ee_sk, ee_di, str_valid}, 6'b0);
    check("R12 reset config", {cfg_vid, cfg_pid}, {D_VID, D_PID});
    check("R12 reset config 2", {cfg_ports, cfg_removable, cfg_maxpwr}, {D_PORTS, D_REM, D_PWR});
  endtask

  task automatic t_absent();
    absent = 1; do_m = 1'b1;
    make_img(16'h1111, 16'h2222, 8'd2, 8'h0F, 8'h10, 1, 3, 3, 3);
    run_load("R3");
    check("R3 absent: one word read", words_read, 1);
    check("R8 absent: present low", ee_present, 1'b0);
    check("R3 absent: defaults", {cfg_vid, cfg_pid, cfg_ports, cfg_removable, cfg_maxpwr},
          {D_VID, D_PID, D_PORTS, D_REM, D_PWR});
    check("R3 absent: no text", cnt_rx[0] + cnt_rx[1] + cnt_rx[2], 0);
    absent = 0;
  endtask

  task automatic t_valid();
    make_img(16'h1234, 16'h5678, 8'd3, 8'h05, 8'h64, 1, 5, 3, 4);
    run_load("R5");
    check("R1 command/address sequence", proto_err, 0);
    check("R1 words read", words_read, 60);
    check("R5 vid/pid", {cfg_vid, cfg_pid}, {16'h1234, 16'h5678});
    check("R5 removable", cfg_removable, 4'h5);
    check("R6 port count 3", cfg_ports, 3'd3);
    check("R7 max power 64h", cfg_maxpwr, 8'h64);
    check("R8 present", ee_present, 1'b1);
    check_text("R9 short strings", 5, 3, 4);
    repeat (5) @(negedge clk);
    check("R11 outputs hold after done", {done, cfg_vid}, {1'b1, 16'h1234});
  endtask

  task automatic t_badsum();
    make_img(16'h1234, 16'h5678, 8'd2, 8'h0F, 8'h20, 0, 5, 5, 5);
    run_load("R4");
    check("R4 bad sum: words read", words_read, 4);
    check("R4 bad sum: defaults", {cfg_vid, cfg_pid, cfg_ports, cfg_removable, cfg_maxpwr},
          {D_VID, D_PID, D_PORTS, D_REM, D_PWR});
    check("R8 bad sum: present", ee_present, 1'b1);
    check("R4 bad sum: no text", cnt_rx[0] + cnt_rx[1] + cnt_rx[2], 0);
  endtask

  task automatic t_wrap();
    make_img(16'hFFFF, 16'hFFFF, 8'd1, 8'h08, 8'h00, 1, 0, 0, 0);
    run_load("R4 wrap");
    check("R4 wrapping sum accepted", {cfg_vid, cfg_pid}, 32'hFFFF_FFFF);
    check("R6 port count 1", cfg_ports, 3'd1);
    check("R7 max power 0", cfg_maxpwr, 8'h00);
    check_text("R9 zero lengths", 0, 0, 0);
  endtask

  task automatic t_ranges();
    make_img(16'h0101, 16'h0202, 8'd0, 8'h00, 8'hFB, 1, 1, 1, 1);
    run_load("R6");
    check("R6 port count 0 rejected", cfg_ports, D_PORTS);
    check("R7 max power FBh rejected", cfg_maxpwr, D_PWR);
    check("R5 fields still taken", cfg_vid, 16'h0101);
    make_img(16'h0101, 16'h0202, 8'd5, 8'h00, 8'hFA, 1, 1, 1, 1);
    run_load("R7");
    check("R6 port count 5 rejected", cfg_ports, D_PORTS);
    check("R7 max power FAh accepted", cfg_maxpwr, 8'hFA);
    make_img(16'h0101, 16'h0202, 8'd2, 8'h00, 8'hFA, 1, 1, 1, 1);
    run_load("R6b");
    check("R6 port count 2 accepted", cfg_ports, 3'd2);
  endtask

  task automatic t_backpressure();
    bp_mode = 1;
    make_img(16'hBEEF, 16'hF00D, 8'd4, 8'h0F, 8'hC8, 1, 47, 47, 20);
    run_load("R10");
    check_text("R10 back-pressure full regions", 47, 47, 20);
    check("R5 removable all", cfg_removable, 4'hF);
    bp_mode = 0;
  endtask

  task automatic t_divider();
    clk_div = 8'd3;
    make_img(16'h0A0B, 16'h0C0D, 8'd3, 8'h02, 8'h10, 0, 0, 0, 0);
    run_load("R2");
    check("R2 sk high min", hi_min, 4);
    check("R2 sk high max", hi_max, 4);
    check("R2 cs gap at least half period", gap_min >= 4, 1);
    clk_div = 8'd1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_absent();
    t_valid();
    t_badsum();
    t_wrap();
    t_ranges();
    t_backpressure();
    t_divider();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule